// File: doc/BRIEF.md
# Carrier Detect Qualifier with Hysteresis

This block turns a raw in-band activity flag, produced every system clock cycle by an upstream level detector, into a qualified carrier-detect indication. The indication only comes on after activity has been seen in a run of consecutive one-millisecond windows. Once on, it stays on through short losses of signal. It goes off only after a fixed stretch with no activity at all, nominally 10 ms. Every activity cycle restarts that stretch.

The carrier-detect pin is active low. A mode input chooses how the pin is driven. In open-drain mode the block enables its driver only to pull low, and the pin otherwise floats high through an outside pull-up. In push-pull mode the driver is always enabled and drives the level. A second output, the frame enable, tells the downstream framing logic when to accept demodulated bits. It is high exactly while carrier is detected. Power down returns the block to the released state and clears all qualification progress.

The window length, the number of qualifying windows and the release timeout are all counts of system clock cycles set by parameters. The defaults assume a 50 MHz clock.

Top module: `carrier_detect_qualifier`

## Requirements
- R1: Reset puts the block in the released state. frame_en_o is 0. In push-pull mode cd_n_o=1 and cd_oe_o=1. In open-drain mode cd_oe_o=0.
- R2: Carrier asserts only after QUAL_WINDOWS consecutive windows of TICK_DIV cycles each contain at least one activity cycle. Any window with no activity restarts the count from zero.
- R3: act_i is sampled every cycle. A single-cycle pulse inside each window qualifies that window just as a steady level does.
- R4: Once asserted, carrier stays asserted through any gap in activity shorter than RELEASE_CYC cycles. It releases after RELEASE_CYC consecutive cycles with no activity, and every activity cycle restarts that count.
- R5: Open-drain mode (mode_i=0): cd_n_o is always 0, and cd_oe_o is 1 exactly while carrier is asserted.
- R6: Push-pull mode (mode_i=1): cd_oe_o is always 1, and cd_n_o is 0 while carrier is asserted and 1 otherwise.
- R7: While pwdn_i=1 the carrier is released in the same cycle, whatever the activity. After pwdn_i returns to 0, a full qualification is needed again.
- R8: frame_en_o is 1 exactly when carrier is asserted, which is the inverse of the effective active-low carrier-detect line.
- R9: With activity present without a break, carrier asserts no later than QUAL_WINDOWS*TICK_DIV+3 cycles after the activity starts. It is still released (QUAL_WINDOWS-1)*TICK_DIV-2 cycles after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwdn_i | input | 1 | Power down, active high |
| mode_i | input | 1 | Pin drive style: 0 open-drain, 1 push-pull |
| act_i | input | 1 | In-band activity flag, sampled every cycle |
| cd_n_o | output | 1 | Active-low carrier-detect level presented to the pin driver |
| cd_oe_o | output | 1 | Driver enable for the carrier-detect pin |
| frame_en_o | output | 1 | Gate that lets the downstream framing logic accept data |

## Verification
The main function is tried with four kinds of input:
- Steady activity shows that qualification completes inside its latency bounds.
- One pulse every ten cycles shows that window detection does not depend on the duty cycle.
- Bursts shorter than the qualifying run, separated by silent windows, must never assert carrier. This separates a run counter that restarts from one that only accumulates.
- After carrier is asserted, a dropout below the timeout followed by a resumption must not release it, while a silence past the timeout must. This tells a restartable hysteresis timer from a fixed hold time.

Both drive modes and power down are checked at the pin-level outputs.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

    localparam logic MODE_OPEN_DRAIN = 1'b0;
    localparam logic MODE_PUSH_PULL  = 1'b1;

    typedef enum logic {
        CD_RELEASED = 1'b0,
        CD_HELD     = 1'b1
    } cd_state_e;

    typedef struct packed {
        logic level_n;
        logic drive_en;
    } pad_drv_t;

    function automatic pad_drv_t cd_pad(input logic mode, input logic asserted);
        pad_drv_t p;
        if (mode == MODE_OPEN_DRAIN) begin
            p.level_n  = 1'b0;
            p.drive_en = asserted;
        end else begin
            p.level_n  = ~asserted;
            p.drive_en = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/cdq_tick_gen.sv
module cdq_tick_gen #(
    parameter int TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)      cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    generate
        if (TICK_DIV > 1) begin : g_gap_chk
            p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
                (tick_o && !clr_i) |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/cdq_qualifier.sv
module cdq_qualifier #(
    parameter int QUAL_WINDOWS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic tick_i,
    input  logic act_i,
    output logic qualified_o
);
    localparam int QW = $clog2(QUAL_WINDOWS + 1);
    localparam logic [QW-1:0] QMAX = QW'(QUAL_WINDOWS);

    logic          win_act_q;
    logic [QW-1:0] run_q;
    logic          seen;

    assign seen = win_act_q | act_i;

    always_ff @(posedge clk) begin
        if (rst || clr_i)  win_act_q <= 1'b0;
        else if (tick_i)   win_act_q <= 1'b0;
        else if (act_i)    win_act_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            run_q <= '0;
        end else if (tick_i) begin
            if (!seen)            run_q <= '0;
            else if (run_q != QMAX) run_q <= run_q + 1'b1;
        end
    end

    assign qualified_o = (run_q == QMAX);

    p_run_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run_q <= QMAX);
    p_silent_window_restarts_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !win_act_q && !act_i) |=> (run_q == '0));

endmodule

// File: rtl/cdq_release_timer.sv
module cdq_release_timer #(
    parameter int RELEASE_CYC = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic act_i,
    output logic expire_o
);
    localparam int SW = $clog2(RELEASE_CYC + 1);
    localparam logic [SW-1:0] SMAX = SW'(RELEASE_CYC);

    logic [SW-1:0] silent_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i || act_i) silent_q <= '0;
        else if (silent_q != SMAX) silent_q <= silent_q + 1'b1;
    end

    assign expire_o = (silent_q == SMAX);

    p_activity_restarts_r4: assert property (@(posedge clk) disable iff (rst)
        act_i |=> !expire_o);

endmodule

// File: rtl/carrier_detect_qualifier.sv
module carrier_detect_qualifier
    import cdq_pkg::*;
#(
    parameter int TICK_DIV     = 50000,
    parameter int QUAL_WINDOWS = 8,
    parameter int RELEASE_CYC  = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwdn_i,
    input  logic mode_i,
    input  logic act_i,
    output logic cd_n_o,
    output logic cd_oe_o,
    output logic frame_en_o
);
    cd_state_e state_q;
    logic      tick;
    logic      qualified;
    logic      expire;
    logic      held;
    logic      asserted;
    pad_drv_t  pad;

    assign held     = (state_q == CD_HELD);
    assign asserted = held && !pwdn_i;

    cdq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (pwdn_i),
        .tick_o (tick)
    );

    cdq_qualifier #(.QUAL_WINDOWS(QUAL_WINDOWS)) u_qual (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (pwdn_i || held),
        .tick_i      (tick),
        .act_i       (act_i),
        .qualified_o (qualified)
    );

    cdq_release_timer #(.RELEASE_CYC(RELEASE_CYC)) u_rel (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (pwdn_i || !held),
        .act_i    (act_i),
        .expire_o (expire)
    );

    always_ff @(posedge clk) begin
        if (rst || pwdn_i) begin
            state_q <= CD_RELEASED;
        end else begin
            unique case (state_q)
                CD_RELEASED: if (qualified) state_q <= CD_HELD;
                CD_HELD:     if (expire)    state_q <= CD_RELEASED;
                default:                    state_q <= CD_RELEASED;
            endcase
        end
    end

    always_comb begin
        pad        = cd_pad(mode_i, asserted);
        cd_n_o     = pad.level_n;
        cd_oe_o    = pad.drive_en;
        frame_en_o = asserted;
    end

    p_pwdn_release_r7: assert property (@(posedge clk) disable iff (rst)
        pwdn_i |=> (state_q == CD_RELEASED));
    p_assert_needs_qual_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(held) |-> $past(qualified));
    p_release_needs_silence_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(held) |-> ($past(expire) || $past(pwdn_i)));
    p_od_never_drives_high_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_OPEN_DRAIN) |-> (cd_n_o == 1'b0));
    p_pp_always_driven_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_PUSH_PULL) |-> cd_oe_o);
    p_gate_matches_line_r8: assert property (@(posedge clk) disable iff (rst)
        frame_en_o |-> (cd_oe_o && !cd_n_o));

endmodule

// File: tb/carrier_detect_qualifier_bench.sv
module carrier_detect_qualifier_bench;

    localparam int TD = 20;
    localparam int QW = 4;
    localparam int RC = 200;

    logic clk = 1'b0;
    logic rst, pwdn, mode, act;
    logic cd_n, cd_oe, fen;

    int checks = 0;
    int fails  = 0;

    always #10ns clk = ~clk;

    carrier_detect_qualifier #(
        .TICK_DIV(TD), .QUAL_WINDOWS(QW), .RELEASE_CYC(RC)
    ) u_carrier_detect_qualifier (
        .clk(clk), .rst(rst), .pwdn_i(pwdn), .mode_i(mode), .act_i(act),
        .cd_n_o(cd_n), .cd_oe_o(cd_oe), .frame_en_o(fen)
    );

    // phase vector: {mode, pattern(2b), cycles(12b), exp_on}
    // pattern: 0 silent, 1 steady, 2 one pulse every 10 cycles
    localparam int NPH = 9;
    localparam logic [15:0] PH [NPH] = '{
        {1'b1, 2'd0, 12'd100, 1'b0},   // R1 idle
        {1'b1, 2'd1, 12'd100, 1'b1},   // R2 qualify
        {1'b1, 2'd0, 12'd150, 1'b1},   // R4 short dropout
        {1'b1, 2'd1, 12'd30,  1'b1},   // R4 resume
        {1'b1, 2'd0, 12'd210, 1'b0},   // R4 timeout
        {1'b1, 2'd2, 12'd100, 1'b1},   // R3 pulses
        {1'b1, 2'd0, 12'd210, 1'b0},   // R4 release
        {1'b0, 2'd1, 12'd100, 1'b1},   // R5 open drain on
        {1'b0, 2'd0, 12'd210, 1'b0}    // R5 open drain off
    };

    task automatic drive(input int n, input int pat);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            act = (pat == 1) || (pat == 2 && (i % 10) == 0);
        end
        @(negedge clk);
        act = 1'b0;
    endtask

    task automatic expect_state(input logic on, input string req);
        logic e_n, e_oe, e_line;
        e_n  = (mode == 1'b0) ? 1'b0 : ~on;
        e_oe = (mode == 1'b0) ? on : 1'b1;
        e_line = cd_oe ? cd_n : 1'b1;
        checks++;
        if (cd_n !== e_n || cd_oe !== e_oe || fen !== on || e_line !== ~on) begin
            fails++;
            $display("FAIL %s: cd_n=%b cd_oe=%b fen=%b expected cd_n=%b cd_oe=%b fen=%b",
                     req, cd_n, cd_oe, fen, e_n, e_oe, on);
        end
    endtask

    initial begin
        #(20ns * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; pwdn = 1'b0; mode = 1'b1; act = 1'b0;
        repeat (3) @(negedge clk);
        expect_state(1'b0, "R1 reset push-pull");
        mode = 1'b0; #1ns;
        expect_state(1'b0, "R1 reset open-drain");
        mode = 1'b1;
        rst = 1'b0;

        for (int k = 0; k < NPH; k++) begin
            mode = PH[k][15];
            drive(int'(PH[k][12:1]) - 1, int'(PH[k][14:13]));
            expect_state(PH[k][0], $sformatf("R2/R3/R4/R5/R6/R8 phase %0d", k));
        end

        // R2: bursts too short to qualify, with a silent window in between
        mode = 1'b1;
        for (int b = 0; b < 5; b++) begin
            drive(2*TD - 1, 1);
            drive(44, 0);
            expect_state(1'b0, "R2 broken run never asserts");
        end

        // R9: latency bounds under steady activity
        drive((QW-1)*TD - 3, 1);
        act = 1'b1;
        expect_state(1'b0, "R9 not yet asserted");
        drive(TD + 4, 1);
        act = 1'b1;
        expect_state(1'b1, "R9 asserted by bound");
        // R4: release boundary
        act = 1'b0;
        drive(RC - 4, 0);
        expect_state(1'b1, "R4 held before timeout");
        drive(6, 0);
        expect_state(1'b0, "R4 released after timeout");

        // R7: power down while held, both modes
        drive(100, 1);
        act = 1'b1;
        expect_state(1'b1, "R7 held before power down");
        pwdn = 1'b1; #1ns;
        expect_state(1'b0, "R7 power down releases at once");
        mode = 1'b0; #1ns;
        expect_state(1'b0, "R7 open-drain floats in power down");
        repeat (3) @(negedge clk);
        expect_state(1'b0, "R7 stays released with activity");
        mode = 1'b1;
        @(negedge clk);
        pwdn = 1'b0;
        drive((QW-1)*TD - 3, 1);
        act = 1'b1;
        expect_state(1'b0, "R7 progress cleared by power down");
        drive(TD + 4, 1);
        expect_state(1'b1, "R7 requalifies after power up");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule